// File: doc/BRIEF.md
# Register Rename Tag Table

This block performs register renaming for a small out-of-order core model. Each decode cycle presents up to two source register indices and an optional destination index. For every source the block answers with either a usable value or the tag of the in-flight instruction that will produce it. When the instruction writes a register, the block hands out a fresh tag and records it as the newest pending writer of that register. Consumers then wait for the tag instead of reading the register file.

Execution units announce finished results on a broadcast port as a (value, tag) pair. A register whose current mapping holds that tag becomes ready and its value is captured in a resolved-value file. Architectural state changes only on the commit port, once speculation on an instruction is settled. Commit also returns the instruction's tag to the free pool. A flush drops every speculative mapping, frees every tag and reloads the resolved-value file from the committed values.

Top module: `rrt_rename_top`

## Requirements
- R1: After reset every register reads as ready with value 0, every tag is free, and a decode that needs a tag is accepted.
- R2: A source register with no pending writer is returned ready, carrying its entry from the resolved-value file.
- R3: An accepted decode with a destination receives the lowest-numbered free tag, so no two in-flight writers share a tag.
- R4: A source register with a pending writer is returned not ready, carrying the tag of the most recent accepted writer of that register.
- R5: A broadcast whose tag equals a register's current mapping makes that register ready with the broadcast value from the next cycle on.
- R6: A broadcast whose tag differs from a register's current mapping (an older writer) leaves that register pending on its newer tag.
- R7: A source whose pending tag is broadcast in the same cycle as decode is returned ready with the broadcast value.
- R8: While no tag is free, dec_ready is low for a decode with a destination, and that decode creates no mapping. A decode without a destination is still accepted.
- R9: Commit updates only the committed value of a register, which becomes visible at the sources after a flush. A completed but uncommitted result is lost on flush. Commit returns its tag to the free pool.
- R10: Flush clears all pending mappings, frees all tags and blocks decode in that cycle. From the next cycle every register is ready with its committed value.
- R11: When an instruction reads and writes the same register, its source sees the mapping that existed before this decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode request present |
| dec_src0_idx | input | IDX_W | First source register index |
| dec_src1_idx | input | IDX_W | Second source register index |
| dec_dst_valid | input | 1 | Instruction writes a destination |
| dec_dst_idx | input | IDX_W | Destination register index |
| dec_ready | output | 1 | Decode can be accepted this cycle |
| dec_dst_tag | output | TAG_W | Tag given to the destination (lowest free) |
| src0_ready | output | 1 | First source value is available |
| src0_tag | output | TAG_W | Producer tag of first source when not ready, else 0 |
| src0_value | output | DATA_W | First source value when ready, else 0 |
| src1_ready | output | 1 | Second source value is available |
| src1_tag | output | TAG_W | Producer tag of second source when not ready, else 0 |
| src1_value | output | DATA_W | Second source value when ready, else 0 |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_value | input | DATA_W | Broadcast result value |
| cm_valid | input | 1 | Commit present |
| cm_idx | input | IDX_W | Register being committed |
| cm_tag | input | TAG_W | Tag released by the commit |
| cm_value | input | DATA_W | Value being committed |
| flush | input | 1 | Discard all speculative state |

## Verification
The bench builds the block with its default values: eight registers, four tags and 16-bit data. Only four tags are in flight, so a handful of decodes empties the pool. That makes the stall, the release of a tag by commit and the full refill after flush all reachable in a short sequence. Eight registers are enough to keep a stale older writer, a newer writer of the same register and unrelated registers apart within one run.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // where a source operand is taken from
  typedef enum logic [1:0] {
    SRC_FILE   = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_WAIT   = 2'd2
  } src_kind_e;

endpackage

// File: rtl/rrt_tag_pool.sv
module rrt_tag_pool #(
  parameter int NUM_TAGS = 4,
  parameter int TAG_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_req,
  input  logic             rel_valid,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             any_free,
  output logic [TAG_W-1:0] alloc_tag
);

  logic [NUM_TAGS-1:0] free_q;
  logic [NUM_TAGS-1:0] free_d;
  logic                free_en;
  logic                found;

  // lowest free tag
  always_comb begin
    alloc_tag = '0;
    found     = 1'b0;
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (free_q[i] && !found) begin
        alloc_tag = TAG_W'(i);
        found     = 1'b1;
      end
    end
  end

  assign any_free = |free_q;
  assign free_en  = flush | alloc_req | rel_valid;

  always_comb begin
    free_d = free_q;
    if (rel_valid) free_d[rel_tag] = 1'b1;
    if (alloc_req && any_free) free_d[alloc_tag] = 1'b0;
    if (flush) free_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= '1;
    end else if (free_en) begin
      free_q <= free_d;
    end
  end

  // R8: the decode side never asks for a tag while the pool is empty
  a_r8_no_grant_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q == '0) |-> !alloc_req);

  // R3: a granted tag is in use in the following cycle
  a_r3_grant_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !flush && !(rel_valid && rel_tag == alloc_tag))
      |=> !free_q[$past(alloc_tag)]);

  // R10: flush returns every tag
  a_r10_flush_frees_all: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (free_q == '1));

endmodule

// File: rtl/rrt_map_table.sv
module rrt_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int IDX_W    = 3,
  parameter int TAG_W    = 2,
  parameter int DATA_W   = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 flush,
  input  logic                                 wr_en,
  input  logic [IDX_W-1:0]                     wr_idx,
  input  logic [TAG_W-1:0]                     wr_tag,
  input  logic                                 bc_valid,
  input  logic [TAG_W-1:0]                     bc_tag,
  input  logic [DATA_W-1:0]                    bc_value,
  input  logic                                 cm_valid,
  input  logic [IDX_W-1:0]                     cm_idx,
  input  logic [DATA_W-1:0]                    cm_value,
  output logic [NUM_ARCH-1:0]                  map_pend,
  output logic [NUM_ARCH-1:0][TAG_W-1:0]       map_tag,
  output logic [NUM_ARCH-1:0][DATA_W-1:0]      rdy_val
);

  logic [NUM_ARCH-1:0]               pend_q, pend_d;
  logic [NUM_ARCH-1:0][TAG_W-1:0]    tag_q, tag_d;
  logic [NUM_ARCH-1:0][DATA_W-1:0]   val_q, val_d;
  logic [NUM_ARCH-1:0][DATA_W-1:0]   arch_q, arch_d;
  logic                              spec_en;

  assign spec_en = flush | wr_en | bc_valid;

  // committed file
  always_comb begin
    arch_d = arch_q;
    if (cm_valid) arch_d[cm_idx] = cm_value;
  end

  // speculative mapping and resolved values
  always_comb begin
    pend_d = pend_q;
    tag_d  = tag_q;
    val_d  = val_q;
    for (int r = 0; r < NUM_ARCH; r++) begin
      if (bc_valid && pend_q[r] && (tag_q[r] == bc_tag)) begin
        pend_d[r] = 1'b0;
        val_d[r]  = bc_value;
      end
    end
    if (wr_en) begin
      pend_d[wr_idx] = 1'b1;
      tag_d[wr_idx]  = wr_tag;
    end
    if (flush) begin
      pend_d = '0;
      val_d  = arch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arch_q <= '0;
    end else if (cm_valid) begin
      arch_q <= arch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      tag_q  <= '0;
      val_q  <= '0;
    end else if (spec_en) begin
      pend_q <= pend_d;
      tag_q  <= tag_d;
      val_q  <= val_d;
    end
  end

  assign map_pend = pend_q;
  assign map_tag  = tag_q;
  assign rdy_val  = val_q;

  // R4: an accepted writer becomes the recorded producer
  a_r4_writer_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (pend_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));

  // R10: no mapping survives a flush
  a_r10_flush_clears_map: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pend_q == '0));

endmodule

// File: rtl/rrt_src_lookup.sv
module rrt_src_lookup
  import rrt_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int IDX_W    = 3,
  parameter int TAG_W    = 2,
  parameter int DATA_W   = 16
) (
  input  logic [IDX_W-1:0]                 idx,
  input  logic [NUM_ARCH-1:0]              map_pend,
  input  logic [NUM_ARCH-1:0][TAG_W-1:0]   map_tag,
  input  logic [NUM_ARCH-1:0][DATA_W-1:0]  rdy_val,
  input  logic                             bc_valid,
  input  logic [TAG_W-1:0]                 bc_tag,
  input  logic [DATA_W-1:0]                bc_value,
  output logic                             ready,
  output logic [TAG_W-1:0]                 tag,
  output logic [DATA_W-1:0]                value
);

  src_kind_e kind;

  always_comb begin
    if (!map_pend[idx]) begin
      kind = SRC_FILE;
    end else if (bc_valid && (bc_tag == map_tag[idx])) begin
      kind = SRC_BYPASS;
    end else begin
      kind = SRC_WAIT;
    end
  end

  always_comb begin
    ready = 1'b0;
    tag   = '0;
    value = '0;
    unique case (kind)
      SRC_FILE: begin
        ready = 1'b1;
        value = rdy_val[idx];
      end
      SRC_BYPASS: begin
        ready = 1'b1;
        value = bc_value;
      end
      default: begin
        tag = map_tag[idx];
      end
    endcase
  end

endmodule

// File: rtl/rrt_rename_top.sv
module rrt_rename_top #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_TAGS = 4,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = rrt_pkg::idx_bits(NUM_ARCH),
  localparam int TAG_W   = rrt_pkg::idx_bits(NUM_TAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [IDX_W-1:0]  dec_src0_idx,
  input  logic [IDX_W-1:0]  dec_src1_idx,
  input  logic              dec_dst_valid,
  input  logic [IDX_W-1:0]  dec_dst_idx,
  output logic              dec_ready,
  output logic [TAG_W-1:0]  dec_dst_tag,
  output logic              src0_ready,
  output logic [TAG_W-1:0]  src0_tag,
  output logic [DATA_W-1:0] src0_value,
  output logic              src1_ready,
  output logic [TAG_W-1:0]  src1_tag,
  output logic [DATA_W-1:0] src1_value,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  input  logic              cm_valid,
  input  logic [IDX_W-1:0]  cm_idx,
  input  logic [TAG_W-1:0]  cm_tag,
  input  logic [DATA_W-1:0] cm_value,
  input  logic              flush
);

  localparam int NUM_SRC = 2;

  logic                             any_free;
  logic [TAG_W-1:0]                 free_tag;
  logic                             dec_fire;
  logic                             alloc;
  logic [NUM_ARCH-1:0]              map_pend;
  logic [NUM_ARCH-1:0][TAG_W-1:0]   map_tag;
  logic [NUM_ARCH-1:0][DATA_W-1:0]  rdy_val;
  logic [NUM_SRC-1:0][IDX_W-1:0]    s_idx;
  logic [NUM_SRC-1:0]               s_rdy;
  logic [NUM_SRC-1:0][TAG_W-1:0]    s_tag;
  logic [NUM_SRC-1:0][DATA_W-1:0]   s_val;

  assign dec_ready   = !flush && (!dec_dst_valid || any_free);
  assign dec_fire    = dec_valid && dec_ready;
  assign alloc       = dec_fire && dec_dst_valid;
  assign dec_dst_tag = free_tag;

  rrt_tag_pool #(
    .NUM_TAGS (NUM_TAGS),
    .TAG_W    (TAG_W)
  ) pool_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .alloc_req (alloc),
    .rel_valid (cm_valid),
    .rel_tag   (cm_tag),
    .any_free  (any_free),
    .alloc_tag (free_tag)
  );

  rrt_map_table #(
    .NUM_ARCH (NUM_ARCH),
    .IDX_W    (IDX_W),
    .TAG_W    (TAG_W),
    .DATA_W   (DATA_W)
  ) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (alloc),
    .wr_idx   (dec_dst_idx),
    .wr_tag   (free_tag),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .bc_value (bc_value),
    .cm_valid (cm_valid),
    .cm_idx   (cm_idx),
    .cm_value (cm_value),
    .map_pend (map_pend),
    .map_tag  (map_tag),
    .rdy_val  (rdy_val)
  );

  assign s_idx[0] = dec_src0_idx;
  assign s_idx[1] = dec_src1_idx;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    rrt_src_lookup #(
      .NUM_ARCH (NUM_ARCH),
      .IDX_W    (IDX_W),
      .TAG_W    (TAG_W),
      .DATA_W   (DATA_W)
    ) look_i (
      .idx      (s_idx[g]),
      .map_pend (map_pend),
      .map_tag  (map_tag),
      .rdy_val  (rdy_val),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_value (bc_value),
      .ready    (s_rdy[g]),
      .tag      (s_tag[g]),
      .value    (s_val[g])
    );
  end

  assign src0_ready = s_rdy[0];
  assign src0_tag   = s_tag[0];
  assign src0_value = s_val[0];
  assign src1_ready = s_rdy[1];
  assign src1_tag   = s_tag[1];
  assign src1_value = s_val[1];

endmodule

// File: tb/rrt_rename_top_tb_top.sv
`timescale 1ns/1ps
module rrt_rename_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        dec_valid;
  logic [2:0]  dec_src0_idx, dec_src1_idx, dec_dst_idx;
  logic        dec_dst_valid;
  logic        dec_ready;
  logic [1:0]  dec_dst_tag;
  logic        src0_ready, src1_ready;
  logic [1:0]  src0_tag, src1_tag;
  logic [15:0] src0_value, src1_value;
  logic        bc_valid;
  logic [1:0]  bc_tag;
  logic [15:0] bc_value;
  logic        cm_valid;
  logic [2:0]  cm_idx;
  logic [1:0]  cm_tag;
  logic [15:0] cm_value;
  logic        flush;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rrt_rename_top dut_i (
    .clk (clk), .rst_n (rst_n),
    .dec_valid (dec_valid), .dec_src0_idx (dec_src0_idx), .dec_src1_idx (dec_src1_idx),
    .dec_dst_valid (dec_dst_valid), .dec_dst_idx (dec_dst_idx),
    .dec_ready (dec_ready), .dec_dst_tag (dec_dst_tag),
    .src0_ready (src0_ready), .src0_tag (src0_tag), .src0_value (src0_value),
    .src1_ready (src1_ready), .src1_tag (src1_tag), .src1_value (src1_value),
    .bc_valid (bc_valid), .bc_tag (bc_tag), .bc_value (bc_value),
    .cm_valid (cm_valid), .cm_idx (cm_idx), .cm_tag (cm_tag), .cm_value (cm_value),
    .flush (flush)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    string req;
    bit r0; int v0; int t0;
    bit r1; int v1; int t1;
    bit drdy; bit cd; int dt;
  } exp_t;

  exp_t exp_q[$];
  event sample_ev;

  task automatic cmp(string req, string what, int act, int expv);
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: pops the expected item and compares against the ports
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        cmp(e.req, "src0_ready", int'(src0_ready), int'(e.r0));
        if (e.r0) cmp(e.req, "src0_value", int'(src0_value), e.v0);
        else      cmp(e.req, "src0_tag", int'(src0_tag), e.t0);
        cmp(e.req, "src1_ready", int'(src1_ready), int'(e.r1));
        if (e.r1) cmp(e.req, "src1_value", int'(src1_value), e.v1);
        else      cmp(e.req, "src1_tag", int'(src1_tag), e.t1);
        cmp(e.req, "dec_ready", int'(dec_ready), int'(e.drdy));
        if (e.cd) cmp(e.req, "dec_dst_tag", int'(dec_dst_tag), e.dt);
      end
    end
  end

  // driver side: push expectation and let the monitor sample
  task automatic expect_now(string req, bit r0, int v0, int t0, bit r1, int v1, int t1,
                            bit drdy, bit cd, int dt);
    exp_t e;
    e.req = req; e.r0 = r0; e.v0 = v0; e.t0 = t0;
    e.r1 = r1; e.v1 = v1; e.t1 = t1; e.drdy = drdy; e.cd = cd; e.dt = dt;
    exp_q.push_back(e);
    -> sample_ev;
    #1;
  endtask

  task automatic idle();
    dec_valid = 0; dec_src0_idx = 0; dec_src1_idx = 0;
    dec_dst_valid = 0; dec_dst_idx = 0;
    bc_valid = 0; bc_tag = 0; bc_value = 0;
    cm_valid = 0; cm_idx = 0; cm_tag = 0; cm_value = 0;
    flush = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    dec_src0_idx = 1; dec_src1_idx = 2; dec_dst_valid = 1;
    expect_now("R1", 1, 0, 0, 1, 0, 0, 1, 1, 0);
    // R2: unmapped register reads from the resolved file
    dec_src0_idx = 7; dec_src1_idx = 0;
    expect_now("R2", 1, 0, 0, 1, 0, 0, 1, 1, 0);
    tick();

    // R3: first writer r1 gets tag 0
    dec_valid = 1; dec_dst_valid = 1; dec_dst_idx = 1; dec_src0_idx = 3; dec_src1_idx = 4;
    expect_now("R3", 1, 0, 0, 1, 0, 0, 1, 1, 0);
    tick();

    // R4: r1 pending on tag 0; r2 writer gets tag 1
    dec_valid = 1; dec_dst_valid = 1; dec_dst_idx = 2; dec_src0_idx = 1; dec_src1_idx = 2;
    expect_now("R4", 0, 0, 0, 1, 0, 0, 1, 1, 1);
    tick();

    // R11: read and write r2 in one decode, source sees tag 1, new tag 2
    dec_valid = 1; dec_dst_valid = 1; dec_dst_idx = 2; dec_src0_idx = 2; dec_src1_idx = 0;
    expect_now("R11", 0, 0, 1, 1, 0, 0, 1, 1, 2);
    tick();

    // R6: broadcast of stale tag 1 does not wake r2 (mapped to tag 2)
    bc_valid = 1; bc_tag = 1; bc_value = 16'h0055; dec_src0_idx = 2;
    expect_now("R6", 0, 0, 2, 1, 0, 0, 1, 0, 0);
    tick();
    dec_src0_idx = 2; dec_src1_idx = 1;
    expect_now("R6", 0, 0, 2, 0, 0, 0, 1, 0, 0);
    tick();

    // R7: same-cycle bypass of tag 0 for r1
    bc_valid = 1; bc_tag = 0; bc_value = 16'h1234; dec_valid = 1;
    dec_src0_idx = 1; dec_src1_idx = 2;
    expect_now("R7", 1, 16'h1234, 0, 0, 0, 2, 1, 0, 0);
    tick();

    // R5: r1 now ready from the resolved file
    dec_src0_idx = 1; dec_src1_idx = 0;
    expect_now("R5", 1, 16'h1234, 0, 1, 0, 0, 1, 0, 0);
    tick();

    // R3: r3 writer takes the last free tag 3
    dec_valid = 1; dec_dst_valid = 1; dec_dst_idx = 3;
    expect_now("R3", 1, 0, 0, 1, 0, 0, 1, 1, 3);
    tick();

    // R8: pool empty, destination decode stalls
    dec_valid = 1; dec_dst_valid = 1; dec_dst_idx = 5; dec_src0_idx = 5;
    expect_now("R8", 1, 0, 0, 1, 0, 0, 0, 0, 0);
    tick();
    // R8: stalled decode made no mapping; decode without destination accepted
    dec_valid = 1; dec_src0_idx = 5;
    expect_now("R8", 1, 0, 0, 1, 0, 0, 1, 0, 0);
    tick();

    // R9: commit r1 with tag 0
    cm_valid = 1; cm_idx = 1; cm_tag = 0; cm_value = 16'h1234; dec_src0_idx = 3;
    expect_now("R9", 0, 0, 3, 1, 0, 0, 1, 0, 0);
    tick();
    // R9: tag 0 returned to the pool
    dec_dst_valid = 1;
    expect_now("R9", 1, 0, 0, 1, 0, 0, 1, 1, 0);
    tick();

    // R5: r2 completes (tag 2) but is not committed
    bc_valid = 1; bc_tag = 2; bc_value = 16'h0777;
    tick();
    dec_src0_idx = 2; dec_src1_idx = 1;
    expect_now("R5", 1, 16'h0777, 0, 1, 16'h1234, 0, 1, 0, 0);
    tick();

    // R10: flush blocks decode in its own cycle
    flush = 1; dec_valid = 1; dec_dst_valid = 1; dec_dst_idx = 4; dec_src0_idx = 3;
    expect_now("R10", 0, 0, 3, 1, 0, 0, 0, 0, 0);
    tick();

    // R9: uncommitted r2 result lost, committed r1 kept; R10 all tags free
    dec_src0_idx = 2; dec_src1_idx = 1; dec_dst_valid = 1;
    expect_now("R9", 1, 0, 0, 1, 16'h1234, 0, 1, 1, 0);
    tick();
    // R10: r3 and r4 no longer pending
    dec_src0_idx = 3; dec_src1_idx = 4;
    expect_now("R10", 1, 0, 0, 1, 0, 0, 1, 0, 0);
    tick();

    // R3: allocation restarts from tag 0 after flush
    dec_valid = 1; dec_dst_valid = 1; dec_dst_idx = 6;
    expect_now("R3", 1, 0, 0, 1, 0, 0, 1, 1, 0);
    tick();
    dec_valid = 1; dec_dst_valid = 1; dec_dst_idx = 7; dec_src0_idx = 6;
    expect_now("R3", 0, 0, 0, 1, 0, 0, 1, 1, 1);
    tick();

    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule